// File: doc/BRIEF.md
# Banked UART Configuration Register File

This block is the byte-wide configuration store of a UART. Software reaches it through a small bus made of an address, write data, a write strobe and a read strobe. Reads are combinational and have no side effects. The block drives the configuration of the serial shifter, the FIFOs and the interrupt logic as plain outputs. It does not contain any of those blocks.

Only eight offsets exist, so several registers share the same offset. The last value written to the line control register chooses the access bank, and the bank decides which physical register each shared offset reaches:

- **Operational** (line control bit 7 clear): interrupt enables, FIFO control and modem control.
- **Configuration A** (bit 7 set, any value other than 0xBF): the divisor bytes, FIFO control and modem control.
- **Configuration B** (exactly 0xBF): the divisor bytes and an enhanced-feature register.

Two more functions sit in the same block:

- **Write lock:** the enhanced-enable bit locks the modem control bit that exposes the trigger/threshold registers.
- **Soft reset:** a soft-reset request returns every register to its default. A reset-done flag reports when the sequence has finished.

Offset map (offset: operational / configuration A / configuration B):

| Offset | Operational | Configuration A | Configuration B |
|---|---|---|---|
| 0 | unmapped | divisor low | divisor low |
| 1 | interrupt enable | divisor high | divisor high |
| 2 | FIFO control | FIFO control | enhanced feature |
| 3 | line control | line control | line control |
| 4 | modem control | modem control | unmapped |
| 5 | mode | mode | mode |
| 6 | system control (write only) | system control (write only) | system control (write only) |
| 7 | status (read only) | status (read only) | status (read only) |

Top module: `uart_cfg_regfile`

## Requirements
- R1: Offset 3 reaches the line control register in every bank and reads back what was written. bank_o reports the bank selected by that value: 2 for exactly 0xBF, 1 for any other value with bit 7 set, and 0 when bit 7 is clear. The new bank takes effect in the cycle after the write.
- R2: In banks 1 and 2, offset 0 reaches the divisor low byte and offset 1 reaches the divisor high byte. div_o is {high, low}.
- R3: The interrupt enable register sits at offset 1 and can be reached only in bank 0. A write to offset 1 in bank 1 or 2 leaves ier_o unchanged.
- R4: Offset 2 in banks 0 and 1 is FIFO control, with these fields:
  - bit 0 is the FIFO enable;
  - bits 7:6 are the RX trigger;
  - bits 5:4 are the TX trigger;
  - bits 1 and 2 each raise a one-cycle pulse on rx_fifo_clr_o and tx_fifo_clr_o respectively.
  
  A read of this register returns the write value ANDed with 0xF1.
- R5: Offset 2 in bank 2 is the enhanced-feature register, and its bit 4 drives enh_en_o. Offset 4 in banks 0 and 1 is modem control. Its bit 6 changes only while enh_en_o is 1. Its other bits always take the written value.
- R6: Offset 5 holds a 3-bit mode in every bank and takes a written value in the next cycle. The mode encodings are:
  - 0: 16x UART;
  - 1: slow infrared;
  - 2: 16x UART with autobaud;
  - 3: 13x UART;
  - 4: medium infrared;
  - 5: fast infrared;
  - 6: consumer infrared;
  - 7: disabled.
  
  A read returns the mode in bits 2:0.
- R7: Writing offset 6 with bit 1 set starts a soft reset that behaves as follows:
  - every register returns to its default at that edge;
  - reset_done_o and status bit 0 read 0 for exactly 4 cycles and then read 1;
  - writes made while the reset is in progress are ignored.
- R8: Line control drives the following outputs:
  - bits 1:0: char_len_o;
  - bit 2: two_stop_o;
  - bit 3: par_en_o;
  - bits 5:4: par_type_o (0 odd, 1 even, 2 mark, 3 space);
  - bit 6: break_o.
- R9: The following offsets read 0, and writes to them change no output:
  - offset 0 in bank 0;
  - offset 4 in bank 2;
  - offset 6 in every bank.
- R10: After a hardware reset the block is in these states:
  - every register is 0 except the mode, which is 7;
  - bank_o is 0;
  - reset_done_o is 1;
  - rdata is 0 while rd_en is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Register offset |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational |
| bank_o | output | 2 | Access bank in force |
| div_o | output | 16 | Baud divisor |
| char_len_o | output | 2 | Character length code |
| two_stop_o | output | 1 | Two stop bits |
| par_en_o | output | 1 | Parity enable |
| par_type_o | output | 2 | Parity type |
| break_o | output | 1 | Break control |
| ier_o | output | 8 | Interrupt enables |
| fifo_en_o | output | 1 | FIFO enable |
| rx_trig_o | output | 2 | RX trigger level code |
| tx_trig_o | output | 2 | TX trigger level code |
| rx_fifo_clr_o | output | 1 | One-cycle RX FIFO clear |
| tx_fifo_clr_o | output | 1 | One-cycle TX FIFO clear |
| mcr_o | output | 8 | Modem control |
| enh_en_o | output | 1 | Enhanced-enable bit |
| mode_o | output | 3 | Operating mode |
| reset_done_o | output | 1 | Soft reset finished |

## Verification
The assertions check the following on every cycle:

- writing the configuration-B key always lands in bank 2;
- interrupt enables stay frozen outside bank 0;
- modem control bit 6 stays frozen while the enhanced bit is clear;
- a FIFO clear pulse always follows a FIFO control write that requested it;
- a mode write is always reflected;
- nothing moves while a soft reset is in progress.

Only the bench's scenarios can show the following:

- the full bank decode across all 256 line control values;
- which register each shared offset reaches, and the read-back masks;
- the exact 4-cycle length of the reset-done gap;
- that the soft reset restores every default.

// File: rtl/uart_cfg_pkg.sv
package uart_cfg_pkg;

    localparam int DATA_W = 8;

    // Offsets whose meaning depends on the access bank
    localparam int OFF_DIV_LO   = 0;
    localparam int OFF_DHI_IER  = 1;
    localparam int OFF_FCR_EFR  = 2;
    localparam int OFF_LCR      = 3;
    localparam int OFF_MCR      = 4;
    localparam int OFF_MODE     = 5;
    localparam int OFF_SYSCTL   = 6;
    localparam int OFF_STATUS   = 7;

    localparam int EFR_ENH_BIT  = 4;
    localparam int MCR_THR_BIT  = 6;
    localparam int SRST_BIT     = 1;

    typedef enum logic [1:0] {
        BANK_OP = 2'd0,
        BANK_A  = 2'd1,
        BANK_B  = 2'd2
    } bank_e;

    typedef enum logic [2:0] {
        MODE_U16    = 3'd0,
        MODE_SIR    = 3'd1,
        MODE_U16_AB = 3'd2,
        MODE_U13    = 3'd3,
        MODE_MIR    = 3'd4,
        MODE_FIR    = 3'd5,
        MODE_CIR    = 3'd6,
        MODE_OFF    = 3'd7
    } mode_e;

    typedef struct packed {
        logic [DATA_W-1:0] lcr;
        logic [DATA_W-1:0] div_lo;
        logic [DATA_W-1:0] div_hi;
        logic [DATA_W-1:0] efr;
        logic [DATA_W-1:0] ier;
        logic              fifo_en;
        logic [1:0]        rx_trig;
        logic [1:0]        tx_trig;
        logic [DATA_W-1:0] mcr;
        mode_e             mode;
        logic              rx_clr;
        logic              tx_clr;
    } regs_t;

    function automatic regs_t regs_default();
        regs_t r;
        r         = '0;
        r.mode    = MODE_OFF;
        return r;
    endfunction

endpackage

// File: rtl/uart_cfg_bank_dec.sv
module uart_cfg_bank_dec
    import uart_cfg_pkg::*;
#(
    parameter logic [DATA_W-1:0] KEY_B = 8'hBF
) (
    input  logic [DATA_W-1:0] lcr_i,
    output bank_e             bank_o
);

    always_comb begin
        if (lcr_i == KEY_B) begin
            bank_o = BANK_B;
        end else if (lcr_i[DATA_W-1]) begin
            bank_o = BANK_A;
        end else begin
            bank_o = BANK_OP;
        end
    end

endmodule

// File: rtl/uart_cfg_srst.sv
module uart_cfg_srst #(
    parameter int CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o,
    output logic done_o
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start_i) begin
            cnt_d = CNT_W'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign done_o = (cnt_q == '0);
    assign busy_o = !done_o;

    // R7: done drops right after a start and returns when the count runs out
    p_done_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> !done_o);
    p_done_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CNT_W'(1) && !start_i) |=> done_o);

endmodule

// File: rtl/uart_cfg_rdmux.sv
module uart_cfg_rdmux
    import uart_cfg_pkg::*;
#(
    parameter int ADDR_W = 3
) (
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  bank_e             bank_i,
    input  logic [DATA_W-1:0] lcr_i,
    input  logic [DATA_W-1:0] div_lo_i,
    input  logic [DATA_W-1:0] div_hi_i,
    input  logic [DATA_W-1:0] efr_i,
    input  logic [DATA_W-1:0] ier_i,
    input  logic [DATA_W-1:0] fcr_i,
    input  logic [DATA_W-1:0] mcr_i,
    input  logic [2:0]        mode_i,
    input  logic              done_i,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DATA_W-1:0] sel;

    always_comb begin
        sel = '0;
        case (addr_i)
            ADDR_W'(OFF_DIV_LO): begin
                if (bank_i != BANK_OP) sel = div_lo_i;
            end
            ADDR_W'(OFF_DHI_IER): begin
                sel = (bank_i == BANK_OP) ? ier_i : div_hi_i;
            end
            ADDR_W'(OFF_FCR_EFR): begin
                sel = (bank_i == BANK_B) ? efr_i : fcr_i;
            end
            ADDR_W'(OFF_LCR): sel = lcr_i;
            ADDR_W'(OFF_MCR): begin
                if (bank_i != BANK_B) sel = mcr_i;
            end
            ADDR_W'(OFF_MODE):   sel = {{(DATA_W-3){1'b0}}, mode_i};
            ADDR_W'(OFF_STATUS): sel = {{(DATA_W-1){1'b0}}, done_i};
            default:             sel = '0;
        endcase
        rdata_o = rd_en_i ? sel : '0;
    end

endmodule

// File: rtl/uart_cfg_regfile.sv
module uart_cfg_regfile
    import uart_cfg_pkg::*;
#(
    parameter int               ADDR_W      = 3,
    parameter int               SRST_CYCLES = 4,
    parameter logic [7:0]       KEY_B       = 8'hBF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata,
    output logic [1:0]        bank_o,
    output logic [15:0]       div_o,
    output logic [1:0]        char_len_o,
    output logic              two_stop_o,
    output logic              par_en_o,
    output logic [1:0]        par_type_o,
    output logic              break_o,
    output logic [7:0]        ier_o,
    output logic              fifo_en_o,
    output logic [1:0]        rx_trig_o,
    output logic [1:0]        tx_trig_o,
    output logic              rx_fifo_clr_o,
    output logic              tx_fifo_clr_o,
    output logic [7:0]        mcr_o,
    output logic              enh_en_o,
    output logic [2:0]        mode_o,
    output logic              reset_done_o
);

    regs_t regs_d, regs_q;
    bank_e bank;
    logic  busy, done;
    logic  wr_ok, srst_start;
    logic  [DATA_W-1:0] fcr_view;

    uart_cfg_bank_dec #(.KEY_B(KEY_B)) bank_dec_i (
        .lcr_i  (regs_q.lcr),
        .bank_o (bank)
    );

    uart_cfg_srst #(.CYCLES(SRST_CYCLES)) srst_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (srst_start),
        .busy_o  (busy),
        .done_o  (done)
    );

    assign wr_ok      = wr_en && !busy;
    assign srst_start = wr_ok && (addr == ADDR_W'(OFF_SYSCTL)) && wdata[SRST_BIT];

    always_comb begin
        regs_d        = regs_q;
        regs_d.rx_clr = 1'b0;
        regs_d.tx_clr = 1'b0;
        if (srst_start) begin
            regs_d = regs_default();
        end else if (wr_ok) begin
            case (addr)
                ADDR_W'(OFF_DIV_LO): begin
                    if (bank != BANK_OP) regs_d.div_lo = wdata;
                end
                ADDR_W'(OFF_DHI_IER): begin
                    if (bank == BANK_OP) regs_d.ier    = wdata;
                    else                 regs_d.div_hi = wdata;
                end
                ADDR_W'(OFF_FCR_EFR): begin
                    if (bank == BANK_B) begin
                        regs_d.efr = wdata;
                    end else begin
                        regs_d.fifo_en = wdata[0];
                        regs_d.rx_clr  = wdata[1];
                        regs_d.tx_clr  = wdata[2];
                        regs_d.tx_trig = wdata[5:4];
                        regs_d.rx_trig = wdata[7:6];
                    end
                end
                ADDR_W'(OFF_LCR): regs_d.lcr = wdata;
                ADDR_W'(OFF_MCR): begin
                    if (bank != BANK_B) begin
                        regs_d.mcr = wdata;
                        if (!regs_q.efr[EFR_ENH_BIT]) begin
                            regs_d.mcr[MCR_THR_BIT] = regs_q.mcr[MCR_THR_BIT];
                        end
                    end
                end
                ADDR_W'(OFF_MODE): regs_d.mode = mode_e'(wdata[2:0]);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= regs_default();
        end else begin
            regs_q <= regs_d;
        end
    end

    assign fcr_view = {regs_q.rx_trig, regs_q.tx_trig, 3'b000, regs_q.fifo_en};

    uart_cfg_rdmux #(.ADDR_W(ADDR_W)) rdmux_i (
        .rd_en_i  (rd_en),
        .addr_i   (addr),
        .bank_i   (bank),
        .lcr_i    (regs_q.lcr),
        .div_lo_i (regs_q.div_lo),
        .div_hi_i (regs_q.div_hi),
        .efr_i    (regs_q.efr),
        .ier_i    (regs_q.ier),
        .fcr_i    (fcr_view),
        .mcr_i    (regs_q.mcr),
        .mode_i   (regs_q.mode),
        .done_i   (done),
        .rdata_o  (rdata)
    );

    assign bank_o        = bank;
    assign div_o         = {regs_q.div_hi, regs_q.div_lo};
    assign char_len_o    = regs_q.lcr[1:0];
    assign two_stop_o    = regs_q.lcr[2];
    assign par_en_o      = regs_q.lcr[3];
    assign par_type_o    = regs_q.lcr[5:4];
    assign break_o       = regs_q.lcr[6];
    assign ier_o         = regs_q.ier;
    assign fifo_en_o     = regs_q.fifo_en;
    assign rx_trig_o     = regs_q.rx_trig;
    assign tx_trig_o     = regs_q.tx_trig;
    assign rx_fifo_clr_o = regs_q.rx_clr;
    assign tx_fifo_clr_o = regs_q.tx_clr;
    assign mcr_o         = regs_q.mcr;
    assign enh_en_o      = regs_q.efr[EFR_ENH_BIT];
    assign mode_o        = regs_q.mode;
    assign reset_done_o  = done;

    // R1: writing the key always lands in configuration B
    p_key_bank_b_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && addr == ADDR_W'(OFF_LCR) && wdata == KEY_B) |=> bank_o == BANK_B);

    // R3: interrupt enables are frozen outside the operational bank
    p_ier_lock_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_o != BANK_OP && !srst_start) |=> $stable(ier_o));

    // R4: a clear pulse only follows a FIFO control write that asked for it
    p_rx_clr_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rx_fifo_clr_o |-> $past(wr_en && addr == ADDR_W'(OFF_FCR_EFR) && wdata[1]));
    p_tx_clr_src_r4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_fifo_clr_o |-> $past(wr_en && addr == ADDR_W'(OFF_FCR_EFR) && wdata[2]));

    // R5: threshold-access bit is locked while enhanced features are off
    p_thr_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!enh_en_o && !srst_start) |=> $stable(mcr_o[MCR_THR_BIT]));

    // R6: a mode write is taken as written
    p_mode_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ok && addr == ADDR_W'(OFF_MODE)) |=> mode_o == $past(wdata[2:0]));

    // R7: nothing moves while a soft reset is in progress
    p_busy_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !reset_done_o |=> $stable({div_o, ier_o, mcr_o, mode_o, bank_o, par_type_o}));

endmodule

// File: tb/uart_cfg_regfile_tb.sv
`timescale 1ns/1ps
module uart_cfg_regfile_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [1:0] bank_o;
    logic [15:0] div_o;
    logic [1:0] char_len_o, par_type_o, rx_trig_o, tx_trig_o;
    logic       two_stop_o, par_en_o, break_o, fifo_en_o;
    logic       rx_fifo_clr_o, tx_fifo_clr_o, enh_en_o, reset_done_o;
    logic [7:0] ier_o, mcr_o;
    logic [2:0] mode_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    uart_cfg_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .bank_o(bank_o), .div_o(div_o),
        .char_len_o(char_len_o), .two_stop_o(two_stop_o), .par_en_o(par_en_o),
        .par_type_o(par_type_o), .break_o(break_o), .ier_o(ier_o),
        .fifo_en_o(fifo_en_o), .rx_trig_o(rx_trig_o), .tx_trig_o(tx_trig_o),
        .rx_fifo_clr_o(rx_fifo_clr_o), .tx_fifo_clr_o(tx_fifo_clr_o),
        .mcr_o(mcr_o), .enh_en_o(enh_en_o), .mode_o(mode_o),
        .reset_done_o(reset_done_o)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    // Drive at a falling edge, captured at the next rising edge; returns at the following falling edge
    task automatic wr(input int a, input logic [7:0] d);
        wr_en = 1'b1; addr = a[2:0]; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, input logic [7:0] exp, input string tag);
        rd_en = 1'b1; addr = a[2:0];
        #1;
        chk(rdata, exp, tag);
        rd_en = 1'b0;
    endtask

    function automatic logic [1:0] exp_bank(input logic [7:0] v);
        return (v == 8'hBF) ? 2'd2 : (v[7] ? 2'd1 : 2'd0);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: defaults after hardware reset
        chk(bank_o, 0, "R10 bank");
        chk(mode_o, 7, "R10 mode");
        chk(reset_done_o, 1, "R10 done");
        chk({div_o, ier_o, mcr_o}, 0, "R10 regs");
        chk(rdata, 0, "R10 rdata idle");

        // R1: all line control values select the expected bank
        for (int v = 0; v < 256; v++) begin
            wr(3, v[7:0]);
            chk(bank_o, exp_bank(v[7:0]), "R1 bank");
            rd(3, v[7:0], "R1 lcr readback");
        end

        // R8: line control fields
        wr(3, 8'h6D);
        chk({break_o, par_type_o, par_en_o, two_stop_o, char_len_o},
            {1'b1, 2'b10, 1'b1, 1'b1, 2'b01}, "R8 fields");

        // R2: divisor through bank 2, read back through bank 1
        wr(3, 8'hBF);
        wr(0, 8'h34);
        wr(1, 8'h12);
        chk(div_o, 16'h1234, "R2 div");
        wr(3, 8'h80);
        rd(0, 8'h34, "R2 lo in A");
        rd(1, 8'h12, "R2 hi in A");

        // R3: interrupt enables only in bank 0
        wr(3, 8'h03);
        wr(1, 8'hA5);
        chk(ier_o, 8'hA5, "R3 ier write");
        rd(1, 8'hA5, "R3 ier read");
        wr(3, 8'h83);
        wr(1, 8'h3C);
        chk(ier_o, 8'hA5, "R3 ier locked");
        chk(div_o[15:8], 8'h3C, "R3 offset1 is div hi");

        // R9: unmapped offsets
        wr(3, 8'h00);
        wr(0, 8'h77);
        rd(0, 8'h00, "R9 off0 in bank0");
        chk(div_o, 16'h3C34, "R9 off0 write ignored");
        wr(3, 8'hBF);
        wr(4, 8'h55);
        rd(4, 8'h00, "R9 off4 in bank2");
        chk(mcr_o, 8'h00, "R9 off4 write ignored");
        wr(6, 8'hFD);
        rd(6, 8'h00, "R9 off6 read");
        chk({reset_done_o, mode_o}, {1'b1, 3'd7}, "R9 sysctl no reset");

        // R4: FIFO control sweep in bank 0
        wr(3, 8'h00);
        for (int v = 0; v < 256; v++) begin
            wr(2, v[7:0]);
            chk({rx_trig_o, tx_trig_o, fifo_en_o}, {v[7:6], v[5:4], v[0]}, "R4 fields");
            chk({rx_fifo_clr_o, tx_fifo_clr_o}, {v[1], v[2]}, "R4 pulse");
            rd(2, v[7:0] & 8'hF1, "R4 readback");
        end
        @(negedge clk);
        chk({rx_fifo_clr_o, tx_fifo_clr_o}, 2'b00, "R4 pulse ends");

        // R5: threshold bit locked until enhanced enable is set
        wr(4, 8'hFF);
        chk(mcr_o, 8'hBF, "R5 locked bit6");
        wr(3, 8'hBF);
        wr(2, 8'h10);
        chk(enh_en_o, 1, "R5 enh on");
        rd(2, 8'h10, "R5 efr read");
        wr(3, 8'h80);
        wr(4, 8'h40);
        chk(mcr_o, 8'h40, "R5 bit6 writable");
        wr(3, 8'hBF);
        wr(2, 8'h00);
        wr(3, 8'h00);
        wr(4, 8'h00);
        chk(mcr_o, 8'h40, "R5 bit6 relocked");

        // R6: every mode encoding
        for (int m = 0; m < 8; m++) begin
            wr(5, {5'b10101, m[2:0]});
            chk(mode_o, m[2:0], "R6 mode");
            rd(5, {5'b0, m[2:0]}, "R6 read");
        end

        // R7: soft reset sequence
        wr(5, 8'h03);
        wr(6, 8'h02);
        chk(reset_done_o, 0, "R7 done low c1");
        rd(7, 8'h00, "R7 status low");
        chk({div_o, ier_o, mcr_o, mode_o}, {16'h0, 8'h0, 8'h0, 3'd7}, "R7 defaults");
        wr(5, 8'h01);
        chk(reset_done_o, 0, "R7 done low c2");
        chk(mode_o, 7, "R7 write ignored while busy");
        @(negedge clk);
        chk(reset_done_o, 0, "R7 done low c3");
        @(negedge clk);
        chk(reset_done_o, 0, "R7 done low c4");
        @(negedge clk);
        chk(reset_done_o, 1, "R7 done back");
        rd(7, 8'h01, "R7 status high");

        summary();
        $finish;
    end

endmodule